// File: doc/BRIEF.md
# Bus wait and idle cycle controller

This block sequences accesses on an external bus that is split into four chip-select areas. A 16-bit control register holds, for every area, a 2-bit idle setting and a 2-bit wait setting. A requester offers one access at a time, carrying an area number and a write flag, through a valid/ready handshake. The controller then runs the access in three phases: optional idle (gap) cycles, a base access cycle, and the programmed wait cycles.

Idle cycles keep a slow device that is still driving the data bus from colliding with the next device. Gap cycles are inserted when the area changes, or when a read is followed by a write in the same area. The number of gap cycles comes from the idle setting of the area that was used last. A nonzero wait setting also turns on an external hold input. That input can stretch the access beyond its programmed length. The control register is written and read back through a simple internal port. The long-wait count used by wait setting 3 is a static input.

Top module: `bus_wait_idle_ctrl`

## Requirements
- R1: After reset the control register reads 0xAAFF. A write with `cfg_wr_en` high replaces all 16 bits and reads back from the next cycle onward. The idle field of area n is at bits [9+2n:8+2n] and its wait field is at bits [1+2n:2n].
- R2: The first access after reset gets no gap cycles, whatever its area or direction.
- R3: When the area differs from the previous access, the gap count is 0, 1 or 2 for idle field 00, 01 or 10 of the previous area. The new area's idle field plays no part.
- R4: An idle field of 11 in the previous area gives two gap cycles.
- R5: In the same area, a write after a read gets the previous area's idle count of gap cycles. Read after read, write after write and read after write in the same area get none.
- R6: Wait fields 00, 01 and 10 give accesses that last 1, 2 and 3 cycles of `bus_active` while `ext_wait` is low.
- R7: Wait field 11 gives an access that lasts 4 + `long_wait_sel` cycles while `ext_wait` is low.
- R8: With wait field 00, `ext_wait` has no effect: the access lasts one cycle even while `ext_wait` is held high.
- R9: With a nonzero wait field, `ext_wait` is sampled only in the last programmed wait cycle and in any extra cycles after it. Each cycle in which it is high adds one cycle to the access. A high level in earlier wait cycles adds nothing.
- R10: `req_ready` is high only when no access is in progress. `done` is high for exactly the final `bus_active` cycle of an access. In every cycle exactly one of `req_ready`, `bus_gap` and `bus_active` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr_en | input | 1 | Writes `cfg_wr_data` into the control register |
| cfg_wr_data | input | 16 | New control register value |
| cfg_rd_data | output | 16 | Current control register value |
| long_wait_sel | input | 2 | Static long-wait select; wait setting 3 gives 3 + this many wait cycles |
| req_valid | input | 1 | An access request is offered |
| req_area | input | 2 | Area of the offered access |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_ready | output | 1 | Controller can accept a request |
| ext_wait | input | 1 | External hold request, active high |
| bus_gap | output | 1 | An idle cycle is being inserted |
| bus_active | output | 1 | An access cycle (base or wait) is in progress |
| bus_area | output | 2 | Area of the access in progress |
| bus_write | output | 1 | Direction of the access in progress |
| done | output | 1 | Final cycle of the current access |

## Verification
A request is accepted at the clock edge where `req_valid` and `req_ready` are both high. Gap cycles follow from the next cycle, then the active cycles. `done` is combinational in the final active cycle, and `req_ready` returns in the cycle after it. The bench samples every output one time unit after the falling edge. For each access it counts `bus_gap` and `bus_active` cycles from the cycle after acceptance up to `done`. It then compares the counts with values computed from its own model of the last area, the last direction and the register fields. The bench drives `ext_wait` at the falling edge, based on how many active cycles it has seen so far. It raises `ext_wait` through the earlier wait cycles as well, so a design that samples too early adds extra cycles and the count check catches it.

// File: rtl/bwic_pkg.sv
// Package: shared types and field helpers for the bus wait/idle controller.
// Assumes 2-bit idle and wait fields, one of each per area.
package bwic_pkg;

    localparam int FIELD_W = 2;

    typedef enum logic [1:0] {
        ST_READY = 2'd0,
        ST_GAP   = 2'd1,
        ST_ACC   = 2'd2
    } seq_state_t;

    // Gap cycles for an idle field; the reserved code behaves as two.
    function automatic logic [1:0] idle_count(input logic [FIELD_W-1:0] fld);
        return (fld == 2'b11) ? 2'd2 : fld;
    endfunction

endpackage

// File: rtl/bwic_cfg_reg.sv
// Module: control register holding per-area idle and wait fields.
// Upper half holds idle fields, lower half holds wait fields, area 0 in the
// lowest pair of each half. Assumes whole-register writes only.
module bwic_cfg_reg
    import bwic_pkg::*;
#(
    parameter int N_AREAS = 4,
    localparam int HALF_W = N_AREAS * FIELD_W,
    localparam int REG_W  = 2 * HALF_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [REG_W-1:0]         wr_data,
    output logic [REG_W-1:0]         rd_data,
    output logic [FIELD_W-1:0]       idle_fld [N_AREAS],
    output logic [FIELD_W-1:0]       wait_fld [N_AREAS]
);

    localparam logic [REG_W-1:0] RST_VAL = {{N_AREAS{2'b10}}, {N_AREAS{2'b11}}};

    logic [REG_W-1:0] reg_q;

    // Register storage with synchronous reset to the default setting.
    always_ff @(posedge clk) begin
        if (!rst_n)     reg_q <= RST_VAL;
        else if (wr_en) reg_q <= wr_data;
    end

    assign rd_data = reg_q;

    // Split the register into per-area fields.
    for (genvar a = 0; a < N_AREAS; a++) begin : g_fields
        assign idle_fld[a] = reg_q[HALF_W + a*FIELD_W +: FIELD_W];
        assign wait_fld[a] = reg_q[a*FIELD_W +: FIELD_W];
    end

endmodule

// File: rtl/bwic_turnaround.sv
// Module: tracks the previous access and works out how many gap cycles the
// next one needs. Assumes `accept` marks the cycle a request is taken.
module bwic_turnaround
    import bwic_pkg::*;
#(
    parameter int N_AREAS = 4,
    localparam int AREA_W = $clog2(N_AREAS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               accept,
    input  logic [AREA_W-1:0]  req_area,
    input  logic               req_write,
    input  logic [FIELD_W-1:0] idle_fld [N_AREAS],
    output logic [1:0]         gap_need
);

    logic              has_prev_q;
    logic [AREA_W-1:0] last_area_q;
    logic              last_write_q;
    logic              turn;

    // Record area and direction of each accepted access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            has_prev_q   <= 1'b0;
            last_area_q  <= '0;
            last_write_q <= 1'b0;
        end else if (accept) begin
            has_prev_q   <= 1'b1;
            last_area_q  <= req_area;
            last_write_q <= req_write;
        end
    end

    // A gap is due on an area change or a read-to-write turnaround.
    always_comb begin
        turn     = has_prev_q &&
                   ((req_area != last_area_q) || (!last_write_q && req_write));
        gap_need = turn ? idle_count(idle_fld[last_area_q]) : 2'd0;
    end

endmodule

// File: rtl/bwic_seq.sv
// Module: access sequencer. Runs the gap cycles, then the base cycle and the
// wait cycles, and holds in the last cycle while the external hold input
// is enabled and high. Assumes the wait setting is decoded by the caller.
module bwic_seq
    import bwic_pkg::*;
#(
    parameter int N_AREAS = 4,
    parameter int LW_W    = 2,
    parameter int LW_BASE = 3,
    localparam int AREA_W = $clog2(N_AREAS),
    localparam int CNT_W  = $clog2(LW_BASE + (1 << LW_W))
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [AREA_W-1:0]  req_area,
    input  logic               req_write,
    input  logic [FIELD_W-1:0] req_wait_fld,
    input  logic [LW_W-1:0]    long_wait_sel,
    input  logic [1:0]         gap_need,
    input  logic               ext_wait,
    output logic               req_ready,
    output logic               accept,
    output logic               bus_gap,
    output logic               bus_active,
    output logic [AREA_W-1:0]  bus_area,
    output logic               bus_write,
    output logic               done
);

    seq_state_t        state_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  wait_q;
    logic [CNT_W-1:0]  wait_n;
    logic              ext_en_q;
    logic [AREA_W-1:0] area_q;
    logic              write_q;
    logic              hold;

    // Wait cycles for the requested area's wait setting.
    always_comb begin
        unique case (req_wait_fld)
            2'b00:   wait_n = CNT_W'(0);
            2'b01:   wait_n = CNT_W'(1);
            2'b10:   wait_n = CNT_W'(2);
            default: wait_n = CNT_W'(LW_BASE) + CNT_W'(long_wait_sel);
        endcase
    end

    assign req_ready  = (state_q == ST_READY);
    assign accept     = req_ready && req_valid;
    assign bus_gap    = (state_q == ST_GAP);
    assign bus_active = (state_q == ST_ACC);
    assign bus_area   = area_q;
    assign bus_write  = write_q;
    assign hold       = ext_en_q && ext_wait;
    assign done       = bus_active && (cnt_q == '0) && !hold;

    // Phase sequencing and cycle counting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_READY;
            cnt_q    <= '0;
            wait_q   <= '0;
            ext_en_q <= 1'b0;
            area_q   <= '0;
            write_q  <= 1'b0;
        end else begin
            unique case (state_q)
                ST_READY: if (req_valid) begin
                    area_q   <= req_area;
                    write_q  <= req_write;
                    wait_q   <= wait_n;
                    ext_en_q <= (req_wait_fld != 2'b00);
                    if (gap_need != 2'd0) begin
                        state_q <= ST_GAP;
                        cnt_q   <= CNT_W'(gap_need - 2'd1);
                    end else begin
                        state_q <= ST_ACC;
                        cnt_q   <= wait_n;
                    end
                end
                ST_GAP: begin
                    if (cnt_q == '0) begin
                        state_q <= ST_ACC;
                        cnt_q   <= wait_q;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                ST_ACC: begin
                    if (cnt_q != '0)  cnt_q   <= cnt_q - 1'b1;
                    else if (!hold)   state_q <= ST_READY;
                end
                default: state_q <= ST_READY;
            endcase
        end
    end

endmodule

// File: rtl/bus_wait_idle_ctrl.sv
// Module: top of the bus wait and idle cycle controller. Joins the control
// register, the turnaround tracker and the access sequencer.
// Assumes one outstanding access at a time and a static long-wait select.
module bus_wait_idle_ctrl
    import bwic_pkg::*;
#(
    parameter int N_AREAS = 4,
    parameter int LW_W    = 2,
    parameter int LW_BASE = 3,
    localparam int AREA_W = $clog2(N_AREAS),
    localparam int REG_W  = 2 * N_AREAS * FIELD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_en,
    input  logic [REG_W-1:0]  cfg_wr_data,
    output logic [REG_W-1:0]  cfg_rd_data,
    input  logic [LW_W-1:0]   long_wait_sel,
    input  logic              req_valid,
    input  logic [AREA_W-1:0] req_area,
    input  logic              req_write,
    output logic              req_ready,
    input  logic              ext_wait,
    output logic              bus_gap,
    output logic              bus_active,
    output logic [AREA_W-1:0] bus_area,
    output logic              bus_write,
    output logic              done
);

    logic [FIELD_W-1:0] idle_fld [N_AREAS];
    logic [FIELD_W-1:0] wait_fld [N_AREAS];
    logic [1:0]         gap_need;
    logic               accept;

    bwic_cfg_reg #(.N_AREAS(N_AREAS)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cfg_wr_en),
        .wr_data  (cfg_wr_data),
        .rd_data  (cfg_rd_data),
        .idle_fld (idle_fld),
        .wait_fld (wait_fld)
    );

    bwic_turnaround #(.N_AREAS(N_AREAS)) u_turn (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .req_area  (req_area),
        .req_write (req_write),
        .idle_fld  (idle_fld),
        .gap_need  (gap_need)
    );

    bwic_seq #(.N_AREAS(N_AREAS), .LW_W(LW_W), .LW_BASE(LW_BASE)) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_area      (req_area),
        .req_write     (req_write),
        .req_wait_fld  (wait_fld[req_area]),
        .long_wait_sel (long_wait_sel),
        .gap_need      (gap_need),
        .ext_wait      (ext_wait),
        .req_ready     (req_ready),
        .accept        (accept),
        .bus_gap       (bus_gap),
        .bus_active    (bus_active),
        .bus_area      (bus_area),
        .bus_write     (bus_write),
        .done          (done)
    );

endmodule

// File: rtl/bwic_checker.sv
// Module: protocol checker for the bus wait and idle controller, bound to
// the top module. Observes ports only.
module bwic_checker #(
    parameter int REG_W  = 16,
    parameter int AREA_W = 2,
    parameter logic [REG_W-1:0] RST_VAL = 16'hAAFF
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_wr_en,
    input logic [REG_W-1:0]  cfg_wr_data,
    input logic [REG_W-1:0]  cfg_rd_data,
    input logic              req_valid,
    input logic              req_ready,
    input logic              bus_gap,
    input logic              bus_active,
    input logic [AREA_W-1:0] bus_area,
    input logic              done
);

    // R1: reset loads the default setting.
    a_r1_reset_value: assert property (@(posedge clk)
        !rst_n |=> cfg_rd_data == RST_VAL);

    // R1: a write reads back on the next cycle.
    a_r1_write_back: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr_en |=> cfg_rd_data == $past(cfg_wr_data));

    // R10: exactly one phase indicator at a time.
    a_r10_one_phase: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({req_ready, bus_gap, bus_active}) == 1);

    // R10: done only in an active cycle and lasts one cycle.
    a_r10_done_active: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> bus_active);

    a_r10_done_then_ready: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> req_ready && !done);

    // R10: acceptance starts an access.
    a_r10_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> !req_ready);

    // R3: gap cycles lead into the access, not back to ready.
    a_r3_gap_to_access: assert property (@(posedge clk) disable iff (!rst_n)
        bus_gap |=> bus_gap || bus_active);

    // R9: an access without done carries on in the same area.
    a_r9_active_holds: assert property (@(posedge clk) disable iff (!rst_n)
        bus_active && !done |=> bus_active && $stable(bus_area));

endmodule

bind bus_wait_idle_ctrl bwic_checker #(.REG_W(REG_W), .AREA_W(AREA_W)) u_bwic_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_wr_en   (cfg_wr_en),
    .cfg_wr_data (cfg_wr_data),
    .cfg_rd_data (cfg_rd_data),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .bus_gap     (bus_gap),
    .bus_active  (bus_active),
    .bus_area    (bus_area),
    .done        (done)
);

// File: tb/tb_bus_wait_idle_ctrl.sv
// Bench: sweeps area/direction transitions, wait settings, long-wait values
// and hold lengths; expected gap and access lengths computed arithmetically.
module tb_bus_wait_idle_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [15:0] cfg_wr_data = '0;
    logic [15:0] cfg_rd_data;
    logic [1:0]  long_wait_sel = 2'd0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_area = '0;
    logic        req_write = 1'b0;
    logic        req_ready;
    logic        ext_wait = 1'b0;
    logic        bus_gap;
    logic        bus_active;
    logic [1:0]  bus_area;
    logic        bus_write;
    logic        done;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    // Bench model of the previous access and of the register.
    logic        m_has = 1'b0;
    logic [1:0]  m_area = '0;
    logic        m_wr = 1'b0;
    logic [15:0] m_cfg = 16'hAAFF;

    bus_wait_idle_ctrl dut (.*);

    always #5 clk = ~clk;

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failed check.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_chk++; n_bad++;
            $display("FAIL R10 watchdog: actual hung, expected completion");
            summary();
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        m_has = 1'b0;
        m_cfg = 16'hAAFF;
    endtask

    task automatic write_cfg(input logic [15:0] v);
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_wr_data = v;
        @(negedge clk);
        cfg_wr_en = 1'b0;
        m_cfg = v;
        #1 check("R1 readback", cfg_rd_data, v);
    endtask

    // One access; hold = extra cycles ext_wait stays high past the programmed end.
    task automatic run(input logic [1:0] a, input logic w, input int hold, input string req);
        int exp_gap, exp_act, wcnt, g, act, guard;
        logic [1:0] ifld, wfld;
        ifld = m_cfg[8 + 2*m_area +: 2];
        wfld = m_cfg[2*a +: 2];
        exp_gap = (m_has && (a != m_area || (!m_wr && w))) ?
                  ((ifld == 2'b11) ? 2 : int'(ifld)) : 0;
        wcnt = (wfld == 2'b11) ? 3 + int'(long_wait_sel) : int'(wfld);
        exp_act = 1 + wcnt + ((wfld != 2'b00) ? hold : 0);
        @(negedge clk);
        req_valid = 1'b1; req_area = a; req_write = w; ext_wait = 1'b1;
        #1 check({req, " R10 ready"}, int'(req_ready), 1);
        @(negedge clk);
        req_valid = 1'b0;
        g = 0; act = 0; guard = 0;
        forever begin
            ext_wait = (wfld == 2'b00) ? 1'b1 : (act < wcnt + hold);
            #1;
            if (bus_gap) g++;
            if (bus_active) begin
                act++;
                if (done) break;
            end
            guard++;
            if (guard > 40) break;
            @(negedge clk);
        end
        check({req, " gap count"}, g, exp_gap);
        check({req, " access length"}, act, exp_act);
        @(negedge clk);
        ext_wait = 1'b0;
        #1 check({req, " R10 ready after done"},
                 int'(req_ready && !done && !bus_active), 1);
        m_has = 1'b1; m_area = a; m_wr = w;
    endtask

    initial begin
        do_reset();
        #1 check("R1 reset value", cfg_rd_data, 16'hAAFF);
        check("R10 reset idle", int'(req_ready && !bus_gap && !bus_active), 1);

        // R2: first access gets no gap; reset waits are 11 -> 4+lw cycles (R7).
        long_wait_sel = 2'd1;
        run(2'd3, 1'b1, 0, "R2 R7 first access");
        run(2'd0, 1'b1, 0, "R3 reset idle 10");
        do_reset();
        run(2'd2, 1'b1, 0, "R2 first after second reset");

        // Idle: a0=00 a1=01 a2=10 a3=11; wait: a0=00 a1=01 a2=10 a3=11.
        write_cfg(16'hE4E4);
        long_wait_sel = 2'd0;
        // R3 R4 R5 R6 R7: every pair of area and direction.
        for (int pa = 0; pa < 4; pa++)
            for (int pw = 0; pw < 2; pw++)
                for (int na = 0; na < 4; na++)
                    for (int nw = 0; nw < 2; nw++) begin
                        run(2'(pa), 1'(pw), 0, "R3 R4 R5 R6 prev");
                        run(2'(na), 1'(nw), 0, "R3 R4 R5 R6 next");
                    end

        // R7: long-wait select sweep on area 3.
        for (int lw = 0; lw < 4; lw++) begin
            long_wait_sel = 2'(lw);
            run(2'd3, 1'b0, 0, "R7 long wait");
        end

        // R8 and R9: hold lengths on every area.
        for (int h = 0; h < 3; h++)
            for (int a = 0; a < 4; a++) begin
                run(2'(a), 1'b0, h, (a == 0) ? "R8 hold ignored" : "R9 hold extends");
            end

        // R1: other register values read back, then exercised.
        write_cfg(16'h1B00);
        run(2'd1, 1'b0, 0, "R3 R6 after rewrite");
        run(2'd2, 1'b0, 0, "R3 R6 after rewrite");
        write_cfg(16'h0000);
        run(2'd2, 1'b1, 0, "R5 zero idle");

        summary();
    end

endmodule